// File: doc/BRIEF.md
# Timebase Phase Slide Controller

This block divides a fast timebase clock down to a 1 MHz tick and lets control software move the phase of that tick in fixed steps. A step is made by changing the divider modulus for a counted number of tick periods. Shorter periods advance the clock. Longer periods retard it. Each altered period is longer or shorter than nominal by the count of timebase cycles that equals 200 ns. The tick therefore lands earlier or later by 200 ns per altered period.

Software requests a step with a direction bit and a go pulse. A rate bit selects a step ten times larger, which alters ten consecutive periods instead of one. A free-drive level keeps altering every period for as long as it is held. The adjustment never begins on the period in which it was requested. The first altered period is the one that follows the second tick boundary after the request. A busy bit covers the whole span from the request to the end of the last altered period.

Top module: `phase_slide_ctrl`

## Requirements
- R1: During reset `tick_o` and `busy_o` are low. After reset is released, the first tick pulse appears on the DIV-th clock cycle, with DIV = CLK_HZ/TICK_HZ (20 by default).
- R2: With no request pending, `tick_o` is a one-cycle pulse every DIV clock cycles.
- R3: A request with `dir_i` = 0 (advance) makes each altered period DIV-ADJ cycles long. ADJ is the number of clock cycles in 200 ns (4 by default).
- R4: A request with `dir_i` = 1 (retard) makes each altered period DIV+ADJ cycles long.
- R5: A go request alters exactly one period when `rate10_i` = 0, and exactly ten consecutive periods when `rate10_i` = 1.
- R6: The two tick periods that end at the first and second tick after the request cycle keep the nominal length. The first altered period starts right after the second tick.
- R7: `busy_o` goes high in the cycle after a go or free-drive request is sampled. It stays high through the tick that ends the last altered period, and it is low from the next cycle on. Once an adjustment ends, the following period is nominal.
- R8: A go pulse that arrives while `busy_o` is high is ignored. It neither lengthens nor restarts the adjustment in progress.
- R9: While `free_i` is held high, every period after the start delay of R6 is altered. After `free_i` falls, the period in progress completes altered and the next one is nominal.
- R10: Direction and rate are captured when the request is accepted. Changing `dir_i` or `rate10_i` during an adjustment has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase count clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_i | input | 1 | 0 = advance (shorter periods), 1 = retard (longer periods) |
| go_i | input | 1 | Single-cycle step request pulse |
| rate10_i | input | 1 | 1 selects the tenfold step |
| free_i | input | 1 | Level: continuous adjustment while high |
| tick_o | output | 1 | One-cycle pulse at the end of each tick period |
| busy_o | output | 1 | High while a request is waiting or an adjustment is running |

## Verification
The assertions assume that `go_i` is a pulse lasting exactly one clock cycle, as a control-register write would produce. They also assume that every input changes only between clock edges. They accept only the three legal period lengths, and they tie the rise and fall of `busy_o` to a request and to a tick respectively. The bench drives every input at the falling edge and holds `go_i` for exactly one cycle. It starts each request a few cycles after a tick, so that the request never coincides with a tick boundary. It measures period lengths by counting clock cycles between tick pulses.

// File: rtl/phase_slide_ctrl.sv
`timescale 1ns/1ps
module phase_slide_ctrl #(
  parameter int CLK_HZ    = 20_000_000,
  parameter int TICK_HZ   = 1_000_000,
  parameter int STEP_NS   = 200,
  parameter int LONG_MULT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_i,
  input  logic go_i,
  input  logic rate10_i,
  input  logic free_i,
  output logic tick_o,
  output logic busy_o
);
  localparam int DIV = CLK_HZ / TICK_HZ;
  localparam int ADJ = (CLK_HZ / 1_000_000) * STEP_NS / 1000;
  localparam int CW  = $clog2(DIV + ADJ + 1);
  localparam int RW  = $clog2(LONG_MULT + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} st_t;

  st_t           st;
  logic [CW-1:0] cnt, modulus;
  logic          seen_one;
  logic [RW-1:0] remain;
  logic          dir_r, free_r;

  assign modulus = (st != S_RUN) ? CW'(DIV) :
                   dir_r         ? CW'(DIV + ADJ) : CW'(DIV - ADJ);
  assign tick_o  = (cnt == modulus - 1'b1);
  assign busy_o  = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (tick_o) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      seen_one <= 1'b0;
      remain   <= '0;
      dir_r    <= 1'b0;
      free_r   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (go_i || free_i) begin
          st       <= S_WAIT;
          seen_one <= 1'b0;
          dir_r    <= dir_i;
          free_r   <= free_i;
          remain   <= (rate10_i && !free_i) ? RW'(LONG_MULT) : RW'(1);
        end
        S_WAIT: if (tick_o) begin
          if (seen_one) st <= S_RUN;
          else          seen_one <= 1'b1;
        end
        S_RUN: if (tick_o) begin
          if (free_r && free_i)       st <= S_RUN;
          else if (remain <= RW'(1))  st <= S_IDLE;
          else                        remain <= remain - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n || tick_o) gap <= '0;
    else                  gap <= gap + 1'b1;
  end

  // R2, R3, R4: every period has one of the three legal lengths
  p_period_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> (int'(gap) + 1 == DIV || int'(gap) + 1 == DIV - ADJ || int'(gap) + 1 == DIV + ADJ));

  // R7: busy rises only on a request
  p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(go_i || free_i));

  // R7: busy falls only right after a tick
  p_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(tick_o));

  // R8: a go pulse during an adjustment leaves the remaining count alone
  p_go_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && go_i && !tick_o) |=> $stable(remain));

  // R9: held free drive keeps the block busy
  p_free_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && free_r && free_i) |=> busy_o);
endmodule

// File: tb/phase_slide_ctrl_test.sv
`timescale 1ns/1ps
module phase_slide_ctrl_test;
  localparam int NOM = 20, ADJ = 4, LONGN = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dir_i = 1'b0, go_i = 1'b0, rate10_i = 1'b0, free_i = 1'b0;
  logic tick_o, busy_o;

  always #10 clk = ~clk;

  phase_slide_ctrl uut (
    .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .go_i(go_i),
    .rate10_i(rate10_i), .free_i(free_i), .tick_o(tick_o), .busy_o(busy_o)
  );

  int cyc = 0, last = 0, n = 0;
  int gaps [0:1023];
  bit busy_at [0:1023];
  int checks = 0, fails = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (tick_o) begin
        if (n < 1024) begin
          gaps[n] = cyc - last;
          busy_at[n] = busy_o;
        end
        last = cyc;
        n++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_count(input int target);
    while (n < target) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic align();
    do @(negedge clk); while (!tick_o);
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk("R1 tick in reset", int'(tick_o), 0);
    chk("R1 busy in reset", int'(busy_o), 0);
    rst_n = 1'b1;
    wait_count(4);
    chk("R1 first tick", gaps[0], NOM);
    for (int i = 1; i < 4; i++) chk("R2 idle period", gaps[i], NOM);
  endtask

  task automatic test_step(input bit dir, input bit x10, input bit poke, input string req);
    int s, len, exp;
    align();
    s = n;
    dir_i = dir; rate10_i = x10; go_i = 1'b1;
    @(negedge clk);
    go_i = 1'b0;
    chk("R7 busy after go", int'(busy_o), 1);
    len = x10 ? LONGN : 1;
    exp = dir ? NOM + ADJ : NOM - ADJ;
    if (poke) begin
      wait_count(s + 5);
      go_i = 1'b1; dir_i = ~dir; rate10_i = ~x10;
      @(negedge clk);
      go_i = 1'b0;
    end
    wait_count(s + len + 4);
    chk("R6 first wait period", gaps[s], NOM);
    chk("R6 second wait period", gaps[s + 1], NOM);
    for (int i = 0; i < len; i++) chk(req, gaps[s + 2 + i], exp);
    chk("R5 period after step", gaps[s + 2 + len], NOM);
    chk("R7 busy at last altered tick", int'(busy_at[s + 1 + len]), 1);
    chk("R7 busy after end", int'(busy_at[s + 2 + len]), 0);
    dir_i = 1'b0; rate10_i = 1'b0;
  endtask

  task automatic test_free(input bit dir);
    int s, m, exp;
    align();
    s = n;
    dir_i = dir; free_i = 1'b1;
    @(negedge clk);
    chk("R9 busy after free", int'(busy_o), 1);
    exp = dir ? NOM + ADJ : NOM - ADJ;
    wait_count(s + 7);
    m = n;
    free_i = 1'b0;
    wait_count(m + 3);
    chk("R9 wait period", gaps[s + 1], NOM);
    for (int i = s + 2; i <= m; i++) chk("R9 free period", gaps[i], exp);
    chk("R9 period after release", gaps[m + 1], NOM);
    chk("R9 busy after release", int'(busy_at[m + 1]), 0);
    dir_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    test_reset();
    test_step(1'b0, 1'b0, 1'b0, "R3 advance period");
    test_step(1'b1, 1'b0, 1'b0, "R4 retard period");
    test_step(1'b0, 1'b1, 1'b0, "R5 tenfold advance");
    test_step(1'b1, 1'b1, 1'b0, "R5 tenfold retard");
    test_step(1'b0, 1'b1, 1'b1, "R8 R10 advance with late go and flips");
    test_step(1'b1, 1'b1, 1'b1, "R8 R10 retard with late go and flips");
    test_free(1'b0);
    test_free(1'b1);
    wait_count(n + 3);
    chk("R2 idle after tests", gaps[n - 1], NOM);
    finish_run();
  end
endmodule